// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Port

This block gives a register-mapped path into a word-organised local data memory. Software does not address the memory directly. It loads a pointer into a control register and then moves 32-bit words through a single data register. Two independent step enables sit in the control register. One advances the pointer after each data read. The other advances it after each data write. A read-only configuration register reports how large the memory is.

The memory is split into blocks of 256 bytes (64 words). The byte address held in the control register is block × 256 + offset. Because the read and write step enables are separate, software can run in write-step mode and read the word at the pointer without moving it. It can then merge a partial tail into that word and write it back to the same place.

Requests arrive on a valid/ready channel and each one yields exactly one response beat on a second valid/ready channel. While a response is pending, `req_ready` stays low, so at most one request is in flight. If the consumer holds `rsp_ready` low, the response beat is frozen until it is taken. This is the only back-pressure path, and it stalls the request side.

Top module: `amp_mem_port`

## Requirements
- R1: A control-register write keeps only the byte-offset field (bits 7:0) and the block field (bits 8 upward, log2(NUM_BLOCKS) bits wide, 3 bits by default). All other address bits, 29 down to the top of the block field, are discarded, and a control read returns them as zero.
- R2: The two low bits of a written offset are cleared, so the pointer is always word aligned.
- R3: A data write (select 1) stores the full 32-bit word at the pointer. If write-step (control bit 31) is set, the pointer then advances by one word (4 bytes).
- R4: A data read returns the word at the pointer. If read-step (control bit 30) is set, the pointer then advances by one word.
- R5: When only write-step is set, a data read returns the word at the pointer and leaves the pointer unchanged, which allows a read-modify-write of the same word.
- R6: With neither step bit set, repeated data accesses all hit the same word.
- R7: A step from the last word of the memory (byte address NUM_BLOCKS×256−4) wraps the pointer to zero.
- R8: A configuration read (select 2) returns NUM_BLOCKS in bits 15:0 and the block-size exponent 8 in bits 19:16. Writes to that register have no effect. Select 3 reads as zero.
- R9: Every accepted request yields exactly one response, in order, and `req_ready` is low while a response is pending. A response not yet taken keeps its data stable. Write responses carry zero.
- R10: After reset, the pointer and both step bits are zero, no response is pending, and `req_ready` is high.
- R11: A control-register write is used by the very next data access, with no added wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | 0 control, 1 data, 2 config, 3 unused |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes) |

## Verification
The case that is hardest to reach from the ports is the read-modify-write in write-step mode. The bench has to show that a data read did not move the pointer, and the only way to see the pointer is to read the control register back. The stimulus programs write-step at a mid-block word, reads that word twice, and reads the control register back. It then writes a modified value and re-reads it with stepping off. The wrap case is reached by loading the last-word address directly rather than by streaming the whole memory. Throughout the run, `rsp_ready` is withheld every third cycle, so responses are held under back-pressure.

// File: rtl/amp_pkg.sv
package amp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } amp_sel_e;

  localparam int DW        = 32;
  localparam int RSTEP_BIT = 30;
  localparam int WSTEP_BIT = 31;
endpackage

// File: rtl/amp_word_ram.sv
module amp_word_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/amp_ptr_ctrl.sv
module amp_ptr_ctrl #(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLOCK_WORDS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_we,
  input  logic [31:0]          ctrl_wdata,
  input  logic                 data_rd,
  input  logic                 data_wr,
  output logic [$clog2(NUM_BLOCKS*BLOCK_WORDS)-1:0] ptr,
  output logic                 rstep,
  output logic                 wstep,
  output logic [31:0]          ctrl_rdata
);
  import amp_pkg::*;
  localparam int DEPTH = NUM_BLOCKS * BLOCK_WORDS;
  localparam int PW    = $clog2(DEPTH);
  localparam int TOPB  = PW + 2;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic          step;
  logic [PW-1:0] ptr_inc;
  logic          unused_hi;

  assign unused_hi = ^ctrl_wdata[29:TOPB] ^ ^ctrl_wdata[1:0];
  assign step      = (data_rd && rstep) || (data_wr && wstep);
  assign ptr_inc   = (ptr == LAST) ? '0 : ptr + PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      rstep <= 1'b0;
      wstep <= 1'b0;
    end else if (ctrl_we) begin
      ptr   <= ctrl_wdata[TOPB-1:2];
      rstep <= ctrl_wdata[RSTEP_BIT];
      wstep <= ctrl_wdata[WSTEP_BIT];
    end else if (step) begin
      ptr <= ptr_inc;
    end
  end

  assign ctrl_rdata = {wstep, rstep, {(30-TOPB){1'b0}}, ptr, 2'b00};

  p_wstep_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && wstep && !ctrl_we && ptr != LAST) |=> ptr == $past(ptr) + PW'(1));
  p_rstep_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rstep && !ctrl_we && ptr != LAST) |=> ptr == $past(ptr) + PW'(1));
  p_rmw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rstep && !ctrl_we) |=> $stable(ptr));
  p_same_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !wstep && !ctrl_we) |=> $stable(ptr));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ctrl_we && ptr == LAST) |=> ptr == '0);
endmodule

// File: rtl/amp_rsp_chan.sv
module amp_rsp_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          from_ram,
  input  logic [DW-1:0] imm_data,
  input  logic [DW-1:0] ram_q,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          busy
);
  logic          use_ram;
  logic [DW-1:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      use_ram   <= 1'b0;
      hold      <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      use_ram   <= from_ram;
      hold      <= imm_data;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_rdata = use_ram ? ram_q : hold;
  assign busy      = rsp_valid;

  p_accept_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  p_single_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !accept);
endmodule

// File: rtl/amp_mem_port.sv
module amp_mem_port #(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLOCK_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_sel,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata
);
  import amp_pkg::*;
  localparam int DEPTH   = NUM_BLOCKS * BLOCK_WORDS;
  localparam int PW      = $clog2(DEPTH);
  localparam int BLK_EXP = $clog2(BLOCK_WORDS * 4);
  localparam logic [31:0] CFG_WORD = {12'd0, 4'(BLK_EXP), 16'(NUM_BLOCKS)};

  amp_sel_e      sel;
  logic          accept, busy;
  logic          ctrl_we, data_rd, data_wr;
  logic [PW-1:0] ptr;
  logic          rstep, wstep;
  logic [31:0]   ctrl_rdata, ram_q, imm_data;

  assign sel       = amp_sel_e'(req_sel);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign ctrl_we   = accept &&  req_write && sel == SEL_CTRL;
  assign data_wr   = accept &&  req_write && sel == SEL_DATA;
  assign data_rd   = accept && !req_write && sel == SEL_DATA;

  always_comb begin
    imm_data = '0;
    if (!req_write) begin
      unique case (sel)
        SEL_CTRL: imm_data = ctrl_rdata;
        SEL_CFG:  imm_data = CFG_WORD;
        default:  imm_data = '0;
      endcase
    end
  end

  amp_ptr_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(req_wdata),
    .data_rd(data_rd), .data_wr(data_wr), .ptr(ptr), .rstep(rstep),
    .wstep(wstep), .ctrl_rdata(ctrl_rdata)
  );

  amp_word_ram #(.DEPTH(DEPTH), .AW(PW), .DW(DW)) u_ram (
    .clk(clk), .we(data_wr), .re(data_rd), .addr(ptr),
    .wdata(req_wdata), .rdata(ram_q)
  );

  amp_rsp_chan #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .from_ram(data_rd),
    .imm_data(imm_data), .ram_q(ram_q), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy)
  );

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
endmodule

// File: tb/tb_amp_mem_port.sv
module tb_amp_mem_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_sel = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  amp_mem_port dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", r, act, exp);
    end
  endtask

  // driver: queue the expected response, then present the request
  task automatic issue(input bit wr, input logic [1:0] sel, input logic [31:0] d,
                       input logic [31:0] exp, input string r);
    exp_q.push_back(exp);
    tag_q.push_back(r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor plus back-pressure source
  always @(negedge clk) begin
    cyc++;
    rsp_ready = (cyc % 3) != 1;
    if (rst_n && rsp_valid) begin
      chk(!req_ready, "R9", {31'd0, req_ready}, 32'd0);
      if (rsp_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", rsp_rdata, 32'hDEAD_DEAD);
        else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(rsp_rdata === e, t, rsp_rdata, e);
        end
      end
    end
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [31:0] WS = 32'h8000_0000;
  localparam logic [31:0] RS = 32'h4000_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10", {30'd0, rsp_valid, req_ready}, 32'd1);
    issue(0, 0, 0, 32'h0, "R10");
    // config register and unused select
    issue(0, 2, 0, 32'h0008_0008, "R8");
    issue(1, 2, 32'hFFFF_FFFF, 32'h0, "R8");
    issue(0, 2, 0, 32'h0008_0008, "R8");
    issue(0, 3, 0, 32'h0, "R8");
    // field masking and alignment
    issue(1, 0, 32'h3C00_F357, 32'h0, "R1");
    issue(0, 0, 0, 32'h0000_0354, "R2");
    // streaming writes with write-step
    issue(1, 0, WS | 32'h100, 32'h0, "R3");
    for (int i = 0; i < 4; i++) issue(1, 1, 32'hA000_0000 + i, 32'h0, "R3");
    issue(0, 0, 0, WS | 32'h110, "R3");
    // streaming reads with read-step, used immediately after control write
    issue(1, 0, RS | 32'h100, 32'h0, "R11");
    for (int i = 0; i < 4; i++) issue(0, 1, 0, 32'hA000_0000 + i, "R4");
    issue(0, 0, 0, RS | 32'h110, "R4");
    // read-modify-write in write-step mode
    issue(1, 0, WS | 32'h108, 32'h0, "R5");
    issue(0, 1, 0, 32'hA000_0002, "R5");
    issue(0, 1, 0, 32'hA000_0002, "R5");
    issue(0, 0, 0, WS | 32'h108, "R5");
    issue(1, 1, 32'hA000_00FD, 32'h0, "R5");
    issue(0, 0, 0, WS | 32'h10C, "R5");
    issue(1, 0, 32'h108, 32'h0, "R5");
    issue(0, 1, 0, 32'hA000_00FD, "R5");
    // no stepping: same word
    issue(1, 0, 32'h200, 32'h0, "R6");
    issue(1, 1, 32'hB0B0_0001, 32'h0, "R6");
    issue(1, 1, 32'hC0C0_0002, 32'h0, "R6");
    issue(0, 1, 0, 32'hC0C0_0002, "R6");
    issue(0, 1, 0, 32'hC0C0_0002, "R6");
    issue(0, 0, 0, 32'h200, "R6");
    // wrap from last word
    issue(1, 0, WS | 32'h7FC, 32'h0, "R7");
    issue(1, 1, 32'hD00D_0007, 32'h0, "R7");
    issue(0, 0, 0, WS, "R7");
    issue(1, 0, RS | 32'h7FC, 32'h0, "R7");
    issue(0, 1, 0, 32'hD00D_0007, "R7");
    issue(0, 0, 0, RS, "R7");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule